// File: doc/BRIEF.md
# Load-Use and Branch Stall Accounting Unit

This block keeps cycle accounts for an in-order pipeline without stalling it. Once per retiring instruction it takes the unit class, two source register numbers with their valid flags, a destination register number and a branch-taken flag. It remembers which register the previous retiring instruction loaded. It charges a fixed penalty for every source operand that reads that register before the value could have been forwarded.

Four saturating counters accumulate the results: load-use stall cycles, branch stall cycles, taken control transfers and untaken control transfers. A combinational per-instruction output gives the stall cycles charged to the instruction on the inputs in the current cycle. Performance-analysis logic or a trace unit can read the counters as they run.

Top module: `stall_tally`

## Requirements
- R1: A synchronous reset clears all four counters and forgets any recorded load. The instruction that retires first after reset gets no load-use charge.
- R2: Class encoding on `insn_class`: 0 execute, 1 compare, 2 multiply-accumulate, 3 control transfer, 4 load, 5 store, 6 and 7 other. A load (class 4) records its destination register. For the next retiring instruction of class 0, 1 or 2, each valid source equal to that register adds 2 to `load_stall_cycles`.
- R3: When both sources of a class 0, 1 or 2 instruction name the loaded register, the charge is 4.
- R4: A class 3 instruction checks only source A for a load-use hit. Source B is ignored.
- R5: A taken class 3 instruction adds 2 to `branch_stall_cycles` and 1 to `taken_count`. An untaken one adds 1 to `untaken_count`.
- R6: A store (class 5) records no load, adds no stall and checks no source. Classes 4, 6 and 7 check no source. Any retiring non-load instruction discards the recorded load.
- R7: A source whose valid flag is low never hits.
- R8: Cycles with `retire_valid` low change no counter and keep the recorded load for the next retiring instruction.
- R9: `insn_stall` equals the load-use charge plus the branch charge of the instruction presented this cycle. It is 0 when `retire_valid` is low. The counters update at the next rising clock edge.
- R10: Every counter saturates at its all-ones value and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| retire_valid | input | 1 | An instruction retires this cycle |
| insn_class | input | 3 | Unit class (see R2) |
| src_a | input | REG_W | Source A register number |
| src_a_ok | input | 1 | Source A is present |
| src_b | input | REG_W | Source B register number |
| src_b_ok | input | 1 | Source B is present |
| dst | input | REG_W | Destination register number |
| taken | input | 1 | Control transfer taken |
| insn_stall | output | STALL_W | Stall cycles charged to the current instruction |
| load_stall_cycles | output | CNT_W | Accumulated load-use stall cycles |
| branch_stall_cycles | output | CNT_W | Accumulated taken-branch stall cycles |
| taken_count | output | CNT_W | Taken control transfers |
| untaken_count | output | CNT_W | Untaken control transfers |

## Verification
The bench targets the cases a careless implementation gets wrong:
- A load separated from its reader by an idle cycle must still charge. A design that advanced the recorded load on idle cycles would undercount.
- A store or other instruction in between must clear the recorded load. A design that kept it would overcharge.
- A control transfer must ignore source B even when it names the loaded register.
- An invalid source must never match, even when its number is equal to the loaded register.
- Both sources naming the loaded register must charge twice.

Counters are taken past their all-ones value through a narrower build, so a design that wraps shows a drop to a small value. A reset between a load and its reader must remove the charge.

// File: rtl/stall_tally.sv
module stall_tally #(
  parameter int REG_W    = 4,
  parameter int CNT_W    = 32,
  parameter int LOAD_PEN = 2,
  parameter int BR_PEN   = 2,
  parameter int STALL_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire_valid,
  input  logic [2:0]       insn_class,
  input  logic [REG_W-1:0] src_a,
  input  logic             src_a_ok,
  input  logic [REG_W-1:0] src_b,
  input  logic             src_b_ok,
  input  logic [REG_W-1:0] dst,
  input  logic             taken,
  output logic [STALL_W-1:0] insn_stall,
  output logic [CNT_W-1:0]   load_stall_cycles,
  output logic [CNT_W-1:0]   branch_stall_cycles,
  output logic [CNT_W-1:0]   taken_count,
  output logic [CNT_W-1:0]   untaken_count
);
  localparam int NREG = 1 << REG_W;
  localparam logic [2:0] C_EXEC = 3'd0, C_CMP = 3'd1, C_MAC = 3'd2,
                         C_BR = 3'd3, C_LOAD = 3'd4;
  localparam logic [CNT_W-1:0] LP  = CNT_W'(LOAD_PEN);
  localparam logic [CNT_W-1:0] BP  = CNT_W'(BR_PEN);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  logic [NREG-1:0] active_mask;
  logic [NREG-1:0] pending_mask;
  logic both_checked, a_checked, is_branch;
  logic hit_a, hit_b, br_hit, br_miss;
  logic [CNT_W-1:0] lu_charge, br_charge;

  assign both_checked = retire_valid &&
                        (insn_class == C_EXEC || insn_class == C_CMP || insn_class == C_MAC);
  assign is_branch    = retire_valid && insn_class == C_BR;
  assign a_checked    = both_checked || is_branch;

  assign hit_a = a_checked    && src_a_ok && active_mask[src_a];
  assign hit_b = both_checked && src_b_ok && active_mask[src_b];
  assign br_hit  = is_branch && taken;
  assign br_miss = is_branch && !taken;

  assign lu_charge = (hit_a ? LP : '0) + (hit_b ? LP : '0);
  assign br_charge = br_hit ? BP : '0;
  assign insn_stall = STALL_W'(lu_charge + br_charge);

  assign pending_mask = (retire_valid && insn_class == C_LOAD)
                        ? (NREG'(1) << dst) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_mask         <= '0;
      load_stall_cycles   <= '0;
      branch_stall_cycles <= '0;
      taken_count         <= '0;
      untaken_count       <= '0;
    end else if (retire_valid) begin
      active_mask         <= pending_mask;
      load_stall_cycles   <= sat_add(load_stall_cycles, lu_charge);
      branch_stall_cycles <= sat_add(branch_stall_cycles, br_charge);
      if (br_hit)  taken_count   <= sat_add(taken_count, ONE);
      if (br_miss) untaken_count <= sat_add(untaken_count, ONE);
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (load_stall_cycles == '0 && branch_stall_cycles == '0 &&
             taken_count == '0 && untaken_count == '0));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !retire_valid |=> ($stable(load_stall_cycles) && $stable(branch_stall_cycles) &&
                       $stable(taken_count) && $stable(untaken_count)));

  assert_store_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && insn_class == 3'd5) |=>
      ($stable(load_stall_cycles) && $stable(branch_stall_cycles) &&
       $stable(taken_count) && $stable(untaken_count)));

  assert_untaken_step_R5: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && insn_class == C_BR && !taken) |=>
      ((untaken_count == $past(untaken_count) + ONE || untaken_count == '1) &&
       $stable(taken_count) && $stable(branch_stall_cycles)));

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (load_stall_cycles >= $past(load_stall_cycles) &&
              branch_stall_cycles >= $past(branch_stall_cycles) &&
              taken_count >= $past(taken_count) &&
              untaken_count >= $past(untaken_count)));

  always_comb begin
    if (!rst && !retire_valid)
      assert_quiet_stall_R9: assert (insn_stall == '0);
  end
endmodule

// File: tb/sim_stall_tally.sv
module sim_stall_tally;
  localparam int CW = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic retire_valid = 1'b0;
  logic [2:0] insn_class = '0;
  logic [3:0] src_a = '0, src_b = '0, dst = '0;
  logic src_a_ok = 1'b0, src_b_ok = 1'b0, taken = 1'b0;
  logic [3:0] insn_stall;
  logic [CW-1:0] lsc, bsc, tcnt, ucnt;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int m_prev = -1;
  int m_ls = 0, m_bs = 0, m_tk = 0, m_ut = 0;

  always #5 clk = ~clk;

  stall_tally #(.REG_W(4), .CNT_W(CW), .LOAD_PEN(2), .BR_PEN(2), .STALL_W(4)) u0 (
    .clk(clk), .rst(rst), .retire_valid(retire_valid), .insn_class(insn_class),
    .src_a(src_a), .src_a_ok(src_a_ok), .src_b(src_b), .src_b_ok(src_b_ok),
    .dst(dst), .taken(taken), .insn_stall(insn_stall),
    .load_stall_cycles(lsc), .branch_stall_cycles(bsc),
    .taken_count(tcnt), .untaken_count(ucnt));

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_counters(input string req);
    check({req, " load_stall_cycles"}, int'(lsc), m_ls);
    check({req, " branch_stall_cycles"}, int'(bsc), m_bs);
    check({req, " taken_count"}, int'(tcnt), m_tk);
    check({req, " untaken_count"}, int'(ucnt), m_ut);
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1; retire_valid = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    m_prev = -1; m_ls = 0; m_bs = 0; m_tk = 0; m_ut = 0;
    compare_counters(req);
  endtask

  task automatic step(input bit v, input int cls, input int sa, input bit av,
                      input int sb, input bit bv, input int d, input bit tk,
                      input string req);
    int lu, br;
    @(negedge clk);
    retire_valid = v; insn_class = 3'(cls); src_a = 4'(sa); src_a_ok = av;
    src_b = 4'(sb); src_b_ok = bv; dst = 4'(d); taken = tk;
    lu = 0; br = 0;
    if (v) begin
      if (cls <= 3 && av && m_prev == sa) lu += 2;
      if (cls <= 2 && bv && m_prev == sb) lu += 2;
      if (cls == 3 && tk) br = 2;
    end
    #1;
    check({req, " insn_stall"}, int'(insn_stall), lu + br);
    if (v) begin
      m_ls = sat(m_ls + lu);
      m_bs = sat(m_bs + br);
      if (cls == 3 && tk)  m_tk = sat(m_tk + 1);
      if (cls == 3 && !tk) m_ut = sat(m_ut + 1);
      m_prev = (cls == 4) ? d : -1;
    end
    @(posedge clk); #1;
    compare_counters(req);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    do_reset("R1 reset state");
    step(1, 0, 0, 1, 0, 1, 0, 0, "R1 first insn after reset");

    step(1, 4, 0, 0, 0, 0, 5, 0, "R2 load r5");
    step(1, 0, 5, 1, 2, 1, 1, 0, "R2 exec reads r5 on A");
    step(1, 4, 0, 0, 0, 0, 7, 0, "R2 load r7");
    step(1, 1, 3, 1, 7, 1, 0, 0, "R2 compare reads r7 on B");
    step(1, 4, 0, 0, 0, 0, 9, 0, "R3 load r9");
    step(1, 2, 9, 1, 9, 1, 0, 0, "R3 mac reads r9 twice");

    step(1, 4, 0, 0, 0, 0, 3, 0, "R4 load r3");
    step(1, 3, 1, 1, 3, 1, 0, 1, "R4 branch B ignored");
    step(1, 4, 0, 0, 0, 0, 3, 0, "R4 load r3 again");
    step(1, 3, 3, 1, 0, 0, 0, 1, "R4 R5 taken branch hits A");
    step(1, 3, 3, 1, 0, 0, 0, 0, "R5 untaken branch");

    step(1, 4, 0, 0, 0, 0, 6, 0, "R6 load r6");
    step(1, 5, 6, 1, 6, 1, 6, 0, "R6 store reads r6");
    step(1, 0, 6, 1, 6, 1, 0, 0, "R6 exec after store");
    step(1, 4, 0, 0, 0, 0, 8, 0, "R6 load r8");
    step(1, 4, 8, 1, 8, 1, 2, 0, "R6 load reads r8 records r2");
    step(1, 0, 2, 1, 8, 1, 0, 0, "R6 exec reads r2");
    step(1, 4, 0, 0, 0, 0, 4, 0, "R6 load r4");
    step(1, 6, 4, 1, 4, 1, 0, 0, "R6 other class");
    step(1, 0, 4, 1, 4, 1, 0, 0, "R6 exec after other");

    step(1, 4, 0, 0, 0, 0, 11, 0, "R7 load r11");
    step(1, 0, 11, 0, 11, 0, 0, 0, "R7 invalid sources");

    step(1, 4, 0, 0, 0, 0, 12, 0, "R8 load r12");
    step(0, 0, 12, 1, 12, 1, 0, 1, "R8 idle cycle");
    step(0, 3, 12, 1, 0, 0, 0, 1, "R8 R9 idle branch");
    step(1, 0, 12, 1, 0, 0, 0, 0, "R8 exec after idle");

    step(1, 4, 0, 0, 0, 0, 13, 0, "R1 load before reset");
    do_reset("R1 mid-run reset");
    step(1, 0, 13, 1, 13, 1, 0, 0, "R1 no charge after reset");

    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 7),
           $urandom_range(0, 15), $urandom_range(0, 3) != 0,
           $urandom_range(0, 15), $urandom_range(0, 3) != 0,
           $urandom_range(0, 15), $urandom_range(0, 1) == 1, "R9 mixed stream");
    end

    do_reset("R10 reset before saturation");
    for (int i = 0; i < 70; i++) begin
      step(1, 4, 0, 0, 0, 0, 1, 0, "R10 load r1");
      step(1, 2, 1, 1, 1, 1, 0, 0, "R10 load stall saturation");
    end
    for (int i = 0; i < 260; i++)
      step(1, 3, 0, 0, 0, 0, 0, 1, "R10 taken saturation");
    for (int i = 0; i < 260; i++)
      step(1, 3, 0, 0, 0, 0, 0, 0, "R10 untaken saturation");
    check("R10 load_stall_cycles at max", int'(lsc), MAXC);
    check("R10 taken_count at max", int'(tcnt), MAXC);
    check("R10 untaken_count at max", int'(ucnt), MAXC);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule